// File: doc/BRIEF.md
# Multi-Cycle Peripheral Bus Sequencer

This block connects the control unit of a 16-bit stack processor to a narrow external peripheral bus. The bus has 6 address lines, 8 bidirectional data lines, and three strobes: chip-select, output-enable and write-enable. The control unit hands the block one command at a time. A command is a two-bit operation code, an address and a write byte. There are four operations: store a byte to a peripheral, fetch a byte from one, and write an instruction byte or a data byte to a character display.

Each operation runs for a fixed number of execute cycles. A step counter measures them: it restarts at one when the block is outside the execute state and advances on every clock spent inside it. Store and fetch take three cycles. The two display writes take eight, which gives the display its slower setup and enable window. In the last execute cycle of every command the block raises a one-clock done pulse. This pulse tells the control unit to return to instruction fetch. A fetch also returns the byte it read, zero-extended to 16 bits, so it can be loaded into the top of stack. During the later cycles of a store, the block raises a strobe that tells the stack to drop the two operands the store used.

Top module: `pbus_seq`

## Requirements
- R1: After reset the block is idle. `cmd_ready` is 1. `bus_cs`, `bus_oe`, `bus_we`, `lcd_en`, `lcd_rs`, `stk_pop`, `done` and `rd_valid` are 0, and `bus_addr` is 0.
- R2: Execute lengths are fixed by operation. Store (`cmd_op`=00) and fetch (01) run exactly 3 cycles with `bus_cs` high. Display-instruction write (10) and display-data write (11) run exactly 8. `cmd_ready` is 0 during these cycles and returns to 1 in the cycle after the last one.
- R3: During a store, `bus_cs` is 1 and `bus_oe` is 0 in every execute cycle. `bus_we` is 1 only in execute cycle 1.
- R4: `stk_pop` is 1 in store execute cycles 2 and 3, and 0 at every other time.
- R5: During a fetch, `bus_cs` and `bus_oe` are both 1 and `bus_we` is 0. In the last cycle `rd_valid` is 1 and `rd_data` equals 8'h00 followed by the bus byte present in execute cycle 2. `rd_valid` is 0 at every other time.
- R6: During a display write, `bus_cs` is 1 and `bus_oe` and `bus_we` are 0. `lcd_en` is 1 only in execute cycles 3 to 6. `lcd_rs` is 1 for op 11 and 0 for op 10.
- R7: The block drives `bus_data` with the latched write byte only while `bus_cs` is 1 and `bus_oe` is 0. Otherwise it leaves the lines high-impedance, so a peripheral can drive them during a fetch.
- R8: `done` is 1 for exactly one clock, in the last execute cycle of each command.
- R9: A command is accepted only when `cmd_valid` and `cmd_ready` are both 1 at a clock edge. A `cmd_valid` raised during an execute phase changes neither the running command's length nor its strobes.
- R10: The address and write byte are captured when a command is accepted. `bus_addr` and the driven data then stay at those values for all execute cycles, even if `cmd_addr` and `cmd_wdata` change. `bus_addr` is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 00 store, 01 fetch, 10 display instruction, 11 display data |
| cmd_addr | input | 6 | Peripheral address |
| cmd_wdata | input | 8 | Byte to write |
| cmd_ready | output | 1 | Idle, a command can be accepted |
| done | output | 1 | Last execute cycle, return to fetch |
| rd_valid | output | 1 | Fetch result valid |
| rd_data | output | 16 | Zero-extended fetched byte |
| stk_pop | output | 1 | Drop the store operands from the stack |
| bus_addr | output | 6 | Bus address |
| bus_data | inout | 8 | Bidirectional bus data |
| bus_cs | output | 1 | Chip-select |
| bus_oe | output | 1 | Output-enable (read) |
| bus_we | output | 1 | Write-enable |
| lcd_en | output | 1 | Display enable |
| lcd_rs | output | 1 | Display register select, 1 for data |

## Verification
The bench checks every strobe against its expected value in every execute cycle. This catches a write-enable held past cycle 1, which would repeat the peripheral write, and an operand pop that starts early or also fires on fetches, which would corrupt the stack. It checks the length of each operation type separately, because a counter that starts at zero instead of one gives each command one cycle too many. Fetched bytes with the top bit set check the zero-extension. Fetch cycles check that the bus keeps the peripheral's byte, which would be corrupted if the block drove the lines while reading. Commands are also offered while one is running, with the address and data inputs changing underneath. A design that took the new command or followed its inputs would then show the wrong length or the wrong bus values.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        OP_STORE   = 2'b00,
        OP_FETCH   = 2'b01,
        OP_LCD_CMD = 2'b10,
        OP_LCD_DAT = 2'b11
    } pbus_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } pbus_st_e;

endpackage

// File: rtl/pbus_step_ctr.sv
module pbus_step_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_s;

    ctr_s ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (running) begin
            ctr_d.cnt = ctr_q.cnt + FIRST;
        end else begin
            ctr_d.cnt = FIRST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.cnt <= FIRST;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt = ctr_q.cnt;
endmodule

// File: rtl/pbus_strobe_dec.sv
module pbus_strobe_dec
    import pbus_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 8,
    parameter int EN_FIRST  = 3,
    parameter int EN_LAST   = 6,
    parameter int CAP_CYC   = 2
) (
    input  logic             active,
    input  pbus_op_e         op,
    input  logic [CNT_W-1:0] cnt,
    output logic             cs,
    output logic             oe,
    output logic             we,
    output logic             pop,
    output logic             lcd_en,
    output logic             lcd_rs,
    output logic             drive,
    output logic             capture,
    output logic             last
);
    localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_SHORT = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] C_LONG  = CNT_W'(LONG_CYC);
    localparam logic [CNT_W-1:0] C_ENF   = CNT_W'(EN_FIRST);
    localparam logic [CNT_W-1:0] C_ENL   = CNT_W'(EN_LAST);
    localparam logic [CNT_W-1:0] C_CAP   = CNT_W'(CAP_CYC);

    logic is_lcd;
    logic [CNT_W-1:0] limit;

    always_comb begin
        is_lcd = (op == OP_LCD_CMD) || (op == OP_LCD_DAT);
        limit  = is_lcd ? C_LONG : C_SHORT;

        cs      = 1'b0;
        oe      = 1'b0;
        we      = 1'b0;
        pop     = 1'b0;
        lcd_en  = 1'b0;
        lcd_rs  = 1'b0;
        capture = 1'b0;
        last    = 1'b0;

        if (active) begin
            cs   = 1'b1;
            last = (cnt == limit);
            unique case (op)
                OP_STORE: begin
                    we  = (cnt == C_ONE);
                    pop = (cnt != C_ONE);
                end
                OP_FETCH: begin
                    oe      = 1'b1;
                    capture = (cnt == C_CAP);
                end
                OP_LCD_CMD, OP_LCD_DAT: begin
                    lcd_en = (cnt >= C_ENF) && (cnt <= C_ENL);
                    lcd_rs = (op == OP_LCD_DAT);
                end
                default: ;
            endcase
        end
        drive = cs && !oe;
    end
endmodule

// File: rtl/pbus_pad.sv
module pbus_pad #(
    parameter int W = 8
) (
    inout  wire  [W-1:0] pad,
    input  logic         drive,
    input  logic [W-1:0] dout,
    output logic [W-1:0] din
);
    assign pad = drive ? dout : {W{1'bz}};
    assign din = pad;
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int WORD_W    = 16,
    parameter int SHORT_CYC = 3,
    parameter int LONG_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              done,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              stk_pop,
    output logic [ADDR_W-1:0] bus_addr,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic              bus_cs,
    output logic              bus_oe,
    output logic              bus_we,
    output logic              lcd_en,
    output logic              lcd_rs
);
    localparam int CNT_W    = $clog2(LONG_CYC + 1);
    localparam int EN_FIRST = 3;
    localparam int EN_LAST  = LONG_CYC - 2;
    localparam int CAP_CYC  = SHORT_CYC - 1;
    localparam int PAD_W    = WORD_W - DATA_W;

    typedef struct packed {
        pbus_st_e          st;
        pbus_op_e          op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdcap;
    } seq_s;

    seq_s seq_d, seq_q;

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             drive, capture, last;
    logic [DATA_W-1:0] bus_in;

    assign active = (seq_q.st == ST_EXEC);

    pbus_step_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (active),
        .cnt     (cnt)
    );

    pbus_strobe_dec #(
        .CNT_W     (CNT_W),
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC),
        .EN_FIRST  (EN_FIRST),
        .EN_LAST   (EN_LAST),
        .CAP_CYC   (CAP_CYC)
    ) u_dec (
        .active  (active),
        .op      (seq_q.op),
        .cnt     (cnt),
        .cs      (bus_cs),
        .oe      (bus_oe),
        .we      (bus_we),
        .pop     (stk_pop),
        .lcd_en  (lcd_en),
        .lcd_rs  (lcd_rs),
        .drive   (drive),
        .capture (capture),
        .last    (last)
    );

    pbus_pad #(.W(DATA_W)) u_pad (
        .pad   (bus_data),
        .drive (drive),
        .dout  (seq_q.wdata),
        .din   (bus_in)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    seq_d.st    = ST_EXEC;
                    seq_d.op    = pbus_op_e'(cmd_op);
                    seq_d.addr  = cmd_addr;
                    seq_d.wdata = cmd_wdata;
                end
            end
            ST_EXEC: begin
                if (capture) begin
                    seq_d.rdcap = bus_in;
                end
                if (last) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= ST_IDLE;
            seq_q.op    <= OP_STORE;
            seq_q.addr  <= '0;
            seq_q.wdata <= '0;
            seq_q.rdcap <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmd_ready = !active;
    assign done      = last;
    assign rd_valid  = last && (seq_q.op == OP_FETCH);
    assign rd_data   = {{PAD_W{1'b0}}, seq_q.rdcap};
    assign bus_addr  = active ? seq_q.addr : '0;
endmodule

// File: rtl/pbus_seq_chk.sv
module pbus_seq_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              done,
    input logic              rd_valid,
    input logic              stk_pop,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_cs,
    input logic              bus_oe,
    input logic              bus_we,
    input logic              lcd_en
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!bus_cs && !bus_we && !done && bus_addr == '0)); // R1
    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready); // R2
    AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_cs && !bus_oe)); // R3
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we); // R3
    AST_POP_FOLLOWS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_pop) |-> $past(bus_we)); // R4
    AST_RD_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (done && bus_oe)); // R5
    AST_LCD_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |-> (bus_cs && !bus_oe && !bus_we)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !done) |=> $stable(bus_addr)); // R10
endmodule

bind pbus_seq pbus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .done      (done),
    .rd_valid  (rd_valid),
    .stk_pop   (stk_pop),
    .bus_addr  (bus_addr),
    .bus_cs    (bus_cs),
    .bus_oe    (bus_oe),
    .bus_we    (bus_we),
    .lcd_en    (lcd_en)
);

// File: tb/tb_pbus_seq.sv
module tb_pbus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [5:0]  cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        cmd_ready, done, rd_valid, stk_pop;
    logic [15:0] rd_data;
    logic [5:0]  bus_addr;
    wire  [7:0]  bus_data;
    logic        bus_cs, bus_oe, bus_we, lcd_en, lcd_rs;
    logic [7:0]  periph_byte = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int wd = 0;
    bit finished = 0;

    typedef struct packed {
        logic [1:0] op;
        logic [5:0] addr;
        logic [7:0] data;
        logic [7:0] rdb;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    assign bus_data = (bus_cs && bus_oe) ? periph_byte : 8'hzz;

    pbus_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .done(done), .rd_valid(rd_valid), .rd_data(rd_data), .stk_pop(stk_pop),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_cs(bus_cs),
        .bus_oe(bus_oe), .bus_we(bus_we), .lcd_en(lcd_en), .lcd_rs(lcd_rs)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver: offers a command when idle and records the expectation
    task automatic issue(input logic [1:0] op, input logic [5:0] a, input logic [7:0] d, input logic [7:0] rb);
        exp_t e;
        while (!cmd_ready) @(negedge clk);
        e.op = op; e.addr = a; e.data = d; e.rdb = rb;
        sb.push_back(e);
        periph_byte = rb;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_addr = ~a; cmd_wdata = ~d; // R10: inputs move after capture
    endtask

    // monitor: per-cycle strobe comparison against the queue head
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (bus_cs) begin
                if (sb.size() == 0) begin
                    chk(0, "R9 unexpected command", 16'(bus_cs), 16'h0);
                end else begin
                    exp_t e;
                    int len;
                    bit lcd;
                    e = sb[0];
                    cyc++;
                    lcd = e.op[1];
                    len = lcd ? 8 : 3;
                    chk(cmd_ready == 1'b0, "R9 ready low in exec", 16'(cmd_ready), 16'h0);
                    chk(bus_addr == e.addr, "R10 bus_addr held", 16'(bus_addr), 16'(e.addr));
                    chk(bus_oe == (e.op == 2'b01), "R3/R5/R6 oe", 16'(bus_oe), 16'(e.op == 2'b01));
                    chk(bus_we == (e.op == 2'b00 && cyc == 1), "R3 we first cycle only", 16'(bus_we), 16'(e.op == 2'b00 && cyc == 1));
                    chk(stk_pop == (e.op == 2'b00 && cyc >= 2), "R4 pop", 16'(stk_pop), 16'(e.op == 2'b00 && cyc >= 2));
                    chk(lcd_en == (lcd && cyc >= 3 && cyc <= 6), "R6 lcd_en window", 16'(lcd_en), 16'(lcd && cyc >= 3 && cyc <= 6));
                    chk(lcd_rs == (e.op == 2'b11), "R6 lcd_rs", 16'(lcd_rs), 16'(e.op == 2'b11));
                    if (e.op == 2'b01)
                        chk(bus_data == e.rdb, "R7 bus left to peripheral", 16'(bus_data), 16'(e.rdb));
                    else
                        chk(bus_data == e.data, "R7 R10 driven write byte", 16'(bus_data), 16'(e.data));
                    chk(done == (cyc == len), "R8 done in last cycle", 16'(done), 16'(cyc == len));
                    chk(rd_valid == (e.op == 2'b01 && cyc == len), "R5 rd_valid", 16'(rd_valid), 16'(e.op == 2'b01 && cyc == len));
                    if (cyc == len && e.op == 2'b01)
                        chk(rd_data == {8'h00, e.rdb}, "R5 zero-extended read", rd_data, {8'h00, e.rdb});
                    if (done || cyc > len) begin
                        chk(cyc == len, "R2 execute length", 16'(cyc), 16'(len));
                        void'(sb.pop_front());
                        cyc = 0;
                    end
                end
            end else begin
                if (cyc != 0) begin
                    chk(0, "R2 command ended early", 16'(cyc), 16'h0);
                    void'(sb.pop_front());
                    cyc = 0;
                end
                chk(!done && !bus_we && !stk_pop && !rd_valid && bus_addr == 6'h0,
                    "R1 idle outputs quiet", {done, bus_we, stk_pop, rd_valid, 6'h0, bus_addr}, 16'h0);
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000 && !finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", wd);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1 ready after reset", 16'(cmd_ready), 16'h1);
        chk(!bus_cs && !bus_oe && !bus_we && !lcd_en && !lcd_rs, "R1 strobes low",
            {11'h0, bus_cs, bus_oe, bus_we, lcd_en, lcd_rs}, 16'h0);

        issue(2'b00, 6'h07, 8'h5A, 8'h11);      // R3 R4 store
        issue(2'b00, 6'h04, 8'hA5, 8'h22);      // R3 back-to-back store
        issue(2'b01, 6'h00, 8'h33, 8'h3C);      // R5 fetch
        issue(2'b01, 6'h01, 8'h44, 8'hFF);      // R5 zero extension
        issue(2'b10, 6'h15, 8'h38, 8'h00);      // R6 display instruction
        issue(2'b11, 6'h2A, 8'h41, 8'h00);      // R6 display data

        // R9: a new command offered during a running store is not taken
        issue(2'b00, 6'h3F, 8'hC3, 8'h00);
        cmd_valid = 1'b1; cmd_op = 2'b11; cmd_addr = 6'h12; cmd_wdata = 8'h99;
        @(negedge clk);
        cmd_valid = 1'b0;

        for (int i = 0; i < 12; i++)
            issue(2'(i % 4), 6'(i * 5 + 1), 8'(i * 37 + 3), 8'(8'h80 + i * 13));

        while (!cmd_ready || sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R2 all commands completed", 16'(sb.size()), 16'h0);
        summary();
    end
endmodule